// File: doc/BRIEF.md
# Masked Vector Gather Unit

This block loads up to eight 32-bit elements from memory into an eight-lane destination vector. A single command supplies a base address, one element index per lane, a lane mask that selects the lanes to load, and a starting destination value. The unit does not fetch per element. It issues one 64-byte line read for each distinct cache line the pending lanes touch. When a line returns, every pending lane whose element lies inside that line is filled in the same cycle, and the mask bits of those lanes are cleared.

The gather finishes when the mask is empty. It then pulses a completion strobe and presents the final vector. An interrupt input makes the unit stop after the line currently in flight. The unit then presents the partially filled vector and the mask of lanes still outstanding. Issuing a new command with those two values as mask and destination completes only the remaining lanes. The memory side uses a valid/ready request channel and a response strobe that carries the whole line.

Top module: `vgather_unit`

## Requirements
- R1: Lane i reads the 32-bit word at byte address `base + 4*index[i]` (32-bit wrap). Bits [31:6] of that address are its line number and bits [5:0] are its byte offset within the line.
- R2: Each line request carries the line number of the lowest-numbered lane whose mask bit is still set. A gather issues exactly one request per distinct line among its active lanes.
- R3: In the cycle a line response is taken, every pending lane whose line number equals the returned line is written and has its mask bit cleared. The mask never gains bits during a gather.
- R4: Byte k of the line is `rsp_data[8k+7:8k]`. A lane with offset o receives line bytes o..o+3, with byte o in bits [7:0] of the element.
- R5: Lanes whose mask bit is 0 when the command is taken are never read and keep their starting destination value.
- R6: A command with an all-zero mask makes no request and raises `done` in the cycle right after acceptance.
- R7: `done` is high for one cycle. At that point `res_mask` is zero, `res_dst` holds the final vector, and `busy` is low.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid and its line number does not change.
- R9: If `irq` is seen during a gather, the unit stops after the next line response. If lanes remain, it pulses `halted` for one cycle, presents the partial vector and the nonzero remaining mask, and issues no further request. If no lanes remain, it reports `done` instead.
- R10: Re-issuing a halted gather with `res_mask` and `res_dst` as the new mask and destination yields the same vector as a gather that was never interrupted.
- R11: `busy` is high from acceptance until completion or halt. A command presented while `busy` is high is ignored, and `req_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a gather (taken only when idle) |
| cmd_base | input | 32 | Base byte address |
| cmd_idx | input | LANES*IDX_W | Per-lane element index, lane 0 in the low bits |
| cmd_mask | input | LANES | Lanes to load |
| cmd_dst | input | LANES*32 | Starting destination vector |
| irq | input | 1 | Interrupt request: stop at the next line boundary |
| busy | output | 1 | Gather in progress |
| req_valid | output | 1 | Line read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_line | output | 26 | Requested line number (address bits [31:6]) |
| rsp_valid | input | 1 | Line data valid |
| rsp_data | input | LINE_BYTES*8 | Returned line, byte k in bits [8k+7:8k] |
| done | output | 1 | One-cycle completion strobe |
| halted | output | 1 | One-cycle interrupted-stop strobe |
| res_mask | output | LANES | Remaining mask |
| res_dst | output | LANES*32 | Current destination vector |

## Verification
The command is registered on the accepting edge. `req_valid` therefore appears one cycle after acceptance, and an all-zero mask raises `done` one cycle after acceptance. A response taken at an edge updates `res_dst` and `res_mask`, and raises `done` or `halted`, right after that same edge. The bench drives all inputs on falling edges and reads outputs on the following falling edges. It counts falling edges from acceptance to the strobe, so the zero-mask latency is checked as exactly one cycle, and the completion strobe is checked as low again one cycle later. The memory model in the bench records every request it accepts. This lets it check the number of fetches and the first line number against a count of distinct lines worked out from the lane addresses.

// File: rtl/vg_pkg.sv
package vg_pkg;
  localparam int ADDR_W = 32;
  localparam int ELEM_W = 32;
  localparam int ELEM_BYTES = ELEM_W / 8;

  // Byte address of one lane's element: base + index * element size.
  function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] idx_ext);
    return base + (idx_ext << $clog2(ELEM_BYTES));
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } vg_state_e;
endpackage

// File: rtl/vg_byte_rshift.sv
module vg_byte_rshift #(
  parameter int LINE_BYTES = 64,
  parameter int OUT_W = 32
) (
  input  logic [LINE_BYTES*8-1:0]         line,
  input  logic [$clog2(LINE_BYTES)-1:0]   sh,
  output logic [OUT_W-1:0]                word
);
  localparam int STG = $clog2(LINE_BYTES);
  localparam int W = LINE_BYTES * 8;

  logic [W-1:0] st [STG+1];
  assign st[0] = line;

  // One 2:1 mux level per shift-amount bit: 1, 2, 4, ... bytes.
  for (genvar s = 0; s < STG; s++) begin : g_stage
    assign st[s+1] = sh[s] ? (st[s] >> (8 * (1 << s))) : st[s];
  end

  assign word = st[STG][OUT_W-1:0];
endmodule

// File: rtl/vg_line_match.sv
module vg_line_match #(
  parameter int LANES = 8,
  parameter int TAG_W = 26
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*TAG_W-1:0]  tags,
  output logic [LANES-1:0]        lead_oh,
  output logic [TAG_W-1:0]        lead_tag,
  output logic [LANES-1:0]        hit
);
  // Lowest pending lane leads the fetch.
  assign lead_oh = pend & (~pend + 1'b1);

  always_comb begin
    lead_tag = '0;
    for (int i = 0; i < LANES; i++)
      lead_tag = lead_tag | (tags[i*TAG_W +: TAG_W] & {TAG_W{lead_oh[i]}});
  end

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit[g] = pend[g] && (tags[g*TAG_W +: TAG_W] == lead_tag);
  end
endmodule

// File: rtl/vgather_unit.sv
module vgather_unit
  import vg_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 16,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [ADDR_W-1:0]         cmd_base,
  input  logic [LANES*IDX_W-1:0]    cmd_idx,
  input  logic [LANES-1:0]          cmd_mask,
  input  logic [LANES*ELEM_W-1:0]   cmd_dst,
  input  logic                      irq,
  output logic                      busy,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [TAG_W-1:0]          req_line,
  input  logic                      rsp_valid,
  input  logic [LINE_BYTES*8-1:0]   rsp_data,
  output logic                      done,
  output logic                      halted,
  output logic [LANES-1:0]          res_mask,
  output logic [LANES*ELEM_W-1:0]   res_dst
);
  vg_state_e                state_q;
  logic [ADDR_W-1:0]        base_q;
  logic [LANES*IDX_W-1:0]   idx_q;
  logic [LANES-1:0]         mask_q;
  logic [LANES*ELEM_W-1:0]  dst_q;
  logic                     irq_seen_q;
  logic                     done_q;
  logic                     halt_q;

  // Named internal events, used by the checker.
  logic [LANES*TAG_W-1:0]   lane_tags;
  logic [LANES-1:0]         lead_oh;
  logic [TAG_W-1:0]         lead_tag;
  logic [LANES-1:0]         line_hit;
  logic [LANES-1:0]         mask_after;
  logic                     line_land;
  logic [ELEM_W-1:0]        elem [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = lane_addr(base_q, {{(ADDR_W-IDX_W){1'b0}}, idx_q[g*IDX_W +: IDX_W]});
    assign lane_tags[g*TAG_W +: TAG_W] = a[ADDR_W-1:OFF_W];

    vg_byte_rshift #(.LINE_BYTES(LINE_BYTES), .OUT_W(ELEM_W)) u_ext (
      .line (rsp_data),
      .sh   (a[OFF_W-1:0]),
      .word (elem[g])
    );
  end

  vg_line_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
    .pend     (mask_q),
    .tags     (lane_tags),
    .lead_oh  (lead_oh),
    .lead_tag (lead_tag),
    .hit      (line_hit)
  );

  assign line_land  = (state_q == ST_WAIT) && rsp_valid;
  assign mask_after = mask_q & ~line_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      idx_q      <= '0;
      mask_q     <= '0;
      dst_q      <= '0;
      irq_seen_q <= 1'b0;
      done_q     <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      halt_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          irq_seen_q <= 1'b0;
          if (cmd_valid) begin
            base_q <= cmd_base;
            idx_q  <= cmd_idx;
            mask_q <= cmd_mask;
            dst_q  <= cmd_dst;
            if (cmd_mask == '0) done_q <= 1'b1;
            else                state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (irq) irq_seen_q <= 1'b1;
          if (req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (irq) irq_seen_q <= 1'b1;
          if (line_land) begin
            mask_q <= mask_after;
            for (int i = 0; i < LANES; i++)
              if (line_hit[i]) dst_q[i*ELEM_W +: ELEM_W] <= elem[i];
            if (mask_after == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (irq || irq_seen_q) begin
              halt_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign req_line  = lead_tag;
  assign done      = done_q;
  assign halted    = halt_q;
  assign res_mask  = mask_q;
  assign res_dst   = dst_q;
endmodule

// File: rtl/vgather_chk.sv
module vgather_chk #(
  parameter int LANES = 8,
  parameter int TAG_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              halted,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TAG_W-1:0]  req_line,
  input logic [LANES-1:0]  res_mask,
  input logic [LANES-1:0]  lead_oh,
  input logic [LANES-1:0]  line_hit,
  input logic              line_land
);
  AST_LEAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot(lead_oh) && ((lead_oh & ~res_mask) == '0)); // R2

  AST_HIT_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    line_land |-> (line_hit != '0) && ((line_hit & ~res_mask) == '0)); // R3

  AST_MASK_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((res_mask & ~$past(res_mask)) == '0)); // R3

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_mask == '0) && !busy); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_line)); // R8

  AST_HALT_LEFTOVER: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (res_mask != '0) && !busy && !done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R11
endmodule

bind vgather_unit vgather_chk #(.LANES(LANES), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .halted    (halted),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_line  (req_line),
  .res_mask  (res_mask),
  .lead_oh   (lead_oh),
  .line_hit  (line_hit),
  .line_land (line_land)
);

// File: tb/vgather_unit_test.sv
module vgather_unit_test;
  localparam int LANES = 8;
  localparam int IDX_W = 16;
  localparam int LB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [LANES*IDX_W-1:0] cmd_idx = '0;
  logic [LANES-1:0] cmd_mask = '0;
  logic [LANES*32-1:0] cmd_dst = '0;
  logic irq = 1'b0;
  logic busy, req_valid, done, halted;
  logic req_ready = 1'b0;
  logic [25:0] req_line;
  logic rsp_valid = 1'b0;
  logic [LB*8-1:0] rsp_data = '0;
  logic [LANES-1:0] res_mask;
  logic [LANES*32-1:0] res_dst;

  vgather_unit #(.LANES(LANES), .IDX_W(IDX_W), .LINE_BYTES(LB)) uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int stall = 0;
  int req_n = 0;
  logic [25:0] req_first;
  logic [31:0] t_base;
  logic [15:0] t_idx [LANES];
  logic [LANES-1:0] t_mask;
  logic [31:0] t_dst [LANES];
  logic got_done, got_halt;
  int lat;

  task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [31:0] mw(input logic [31:0] a);
    return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
  endfunction
  function automatic logic [31:0] laddr(input int i);
    return t_base + {14'd0, t_idx[i], 2'b00};
  endfunction
  function automatic logic [LANES*32-1:0] exp_vec();
    logic [LANES*32-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*32 +: 32] = t_mask[i] ? mw(laddr(i)) : t_dst[i];
    return v;
  endfunction
  function automatic int n_lines();
    int n = 0;
    for (int i = 0; i < LANES; i++) begin
      bit seen = 0;
      for (int j = 0; j < i; j++)
        if (t_mask[j] && t_mask[i] && laddr(j)[31:6] == laddr(i)[31:6]) seen = 1;
      if (t_mask[i] && !seen) n++;
    end
    return n;
  endfunction
  function automatic int lead_lane();
    for (int i = 0; i < LANES; i++) if (t_mask[i]) return i;
    return 0;
  endfunction
  function automatic logic [LANES-1:0] first_group();
    logic [LANES-1:0] g = '0;
    for (int i = 0; i < LANES; i++)
      if (t_mask[i] && laddr(i)[31:6] == laddr(lead_lane())[31:6]) g[i] = 1'b1;
    return g;
  endfunction

  // Memory model: accepts a request after 'stall' cycles, returns the line next cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat (stall) @(negedge clk);
        req_ready = 1'b1;
        if (req_n == 0) req_first = req_line;
        req_n++;
        for (int k = 0; k < LB; k++) rsp_data[k*8 +: 8] = mb({req_line, 6'd0} + k);
        @(negedge clk);
        req_ready = 1'b0;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic drive_cmd();
    cmd_base = t_base;
    cmd_mask = t_mask;
    for (int i = 0; i < LANES; i++) begin
      cmd_idx[i*IDX_W +: IDX_W] = t_idx[i];
      cmd_dst[i*32 +: 32] = t_dst[i];
    end
  endtask

  task automatic run_gather();
    req_n = 0;
    @(negedge clk);
    drive_cmd();
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && !halted && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    got_done = done;
    got_halt = halted;
  endtask

  task automatic setup(input logic [31:0] b, input logic [LANES-1:0] m, input int stride, input int ofs);
    t_base = b;
    t_mask = m;
    for (int i = 0; i < LANES; i++) begin
      t_idx[i] = 16'(ofs + i * stride);
      t_dst[i] = 32'hD000_0000 + 32'(i);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !halted && !req_valid && res_mask == 0, "R11 reset",
        {busy, done, halted, req_valid, res_mask}, 0);
  endtask

  task automatic t_one_line();
    setup(32'h0000_4000, 8'hFF, 1, 0);
    run_gather();
    chk(got_done, "R3 one-line done", got_done, 1);
    chk(req_n == 1, "R3 one fetch for shared line", req_n, 1);
    chk(res_dst == exp_vec(), "R4 extracted elements", res_dst, exp_vec());
  endtask

  task automatic t_spread();
    setup(32'h0000_1234, 8'hFF, 5, 0);
    t_idx[0] = 16'd40; t_idx[3] = 16'd2;
    run_gather();
    chk(got_done && res_mask == 0, "R7 spread done", {got_done, res_mask}, 1 << 8);
    chk(req_n == n_lines(), "R2 distinct line count", req_n, n_lines());
    chk(req_first == laddr(lead_lane())[31:6], "R2 leader line", req_first, laddr(lead_lane())[31:6]);
    chk(res_dst == exp_vec(), "R1 lane addressing", res_dst, exp_vec());
  endtask

  task automatic t_partial();
    setup(32'h0001_00F0, 8'b1010_0110, 7, 3);
    run_gather();
    chk(got_done, "R5 partial done", got_done, 1);
    chk(res_dst == exp_vec(), "R5 inactive lanes keep value", res_dst, exp_vec());
    chk(req_n == n_lines(), "R2 partial line count", req_n, n_lines());
  endtask

  task automatic t_zero();
    setup(32'h0000_2000, 8'h00, 1, 0);
    run_gather();
    chk(got_done && lat == 1, "R6 zero mask latency", lat, 1);
    chk(req_n == 0, "R6 no request", req_n, 0);
    chk(res_dst == exp_vec(), "R6 vector unchanged", res_dst, exp_vec());
  endtask

  task automatic t_pulse();
    setup(32'h0000_3000, 8'h0F, 16, 0);
    run_gather();
    chk(got_done && !busy, "R7 busy low at done", {got_done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
  endtask

  task automatic t_stall();
    stall = 3;
    setup(32'h0000_5010, 8'hFF, 9, 1);
    run_gather();
    stall = 0;
    chk(got_done && res_dst == exp_vec(), "R8 result under backpressure", res_dst, exp_vec());
  endtask

  task automatic t_irq();
    logic [LANES*32-1:0] full;
    logic [LANES-1:0] rem;
    setup(32'h0000_6008, 8'hFF, 11, 0);
    full = exp_vec();
    rem = t_mask & ~first_group();
    irq = 1'b1;
    run_gather();
    irq = 1'b0;
    chk(got_halt && !got_done, "R9 halt strobe", {got_halt, got_done}, 2'b10);
    chk(res_mask == rem, "R9 remaining mask", res_mask, rem);
    chk(req_n == 1, "R9 single fetch before stop", req_n, 1);
    @(negedge clk);
    chk(!halted && !req_valid, "R9 stays stopped", {halted, req_valid}, 0);
    t_mask = res_mask;
    for (int i = 0; i < LANES; i++) t_dst[i] = res_dst[i*32 +: 32];
    run_gather();
    chk(got_done && res_dst == full, "R10 restart result", res_dst, full);
  endtask

  task automatic t_busy_ignore();
    logic [LANES*32-1:0] e;
    stall = 2;
    req_n = 0;
    setup(32'h0000_7000, 8'h3C, 20, 0);
    e = exp_vec();
    @(negedge clk);
    drive_cmd();
    cmd_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R11 busy after accept", busy, 1);
    cmd_mask = 8'hFF;
    cmd_dst = '1;
    cmd_base = 32'h0000_9000;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    stall = 0;
    chk(done && res_dst == e, "R11 command while busy ignored", res_dst, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_line();
    t_spread();
    t_partial();
    t_zero();
    t_pulse();
    t_stall();
    t_irq();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule